// File: doc/BRIEF.md
# Paged Address Translator with Granule Write Protection

This block turns a logical address into a physical one through a file of map entries, and checks every write against a bitmap that marks physical memory as write-protected in units finer than a map page. A logical address is split into a page index and a byte offset inside the page. The page index picks an entry in the currently active map bank. A valid entry supplies a physical block number, and the offset is appended to it. The protection bitmap is then indexed by the physical granule that the result falls in.

There are two map banks. While one bank serves translations, the other can be wiped by a background sweep that invalidates one entry per clock. This lets supervisory code prepare a fresh bank for the next task while the current task keeps running. Entries are written one at a time as a program touches new pages.

The map-load, protect-write, bank-select and clear-start ports are supervisory. The requester tags each of them with a privilege flag, and a request without privilege is dropped and reported. The translation port also carries a privilege flag, because protection binds only unprivileged writes.

Top module: `mxl_translate`

## Requirements
- R1: A translation request gives a result one clock later (`xl_vld_o` high). Through a valid entry of the active bank, `xl_paddr_o` is the entry's 11-bit block number in bits 23..13 with the logical offset (logical bits 12..0) in bits 12..0. The page index is logical bits 22..13.
- R2: A translation through an invalid entry raises `xl_fault_o`, drives `xl_paddr_o` to zero and never raises `xl_pviol_o`.
- R3: Physical granule g = paddr[23:11] is protected when bit g[4:0] of protect word g[12:5] is 1. An unprivileged write to a protected granule raises `xl_pviol_o` and drives `xl_paddr_o` to zero. Reads and privileged writes pass whatever the protect bit is.
- R4: A map load, protect write, bank select or clear start with its privilege flag low changes nothing, and `cfg_err_o` is high in the following cycle.
- R5: An accepted clear start invalidates every entry of the bank that is inactive at that moment. `clr_busy_o` stays high for exactly 1024 cycles, and translations through the active bank are unaffected meanwhile.
- R6: While a clear runs, a select of the bank being cleared, a map load into that bank and a second clear start are all refused with `cfg_err_o`, and `act_bank_o` holds.
- R7: A translation in the same cycle as a map load or protect write to the entry or word it uses sees the contents from before that update.
- R8: After reset, bank 0 is active, every entry of both banks is invalid, no granule is protected, and `clr_busy_o` and `cfg_err_o` are low.
- R9: A bank select and a clear start in the same cycle: the select takes effect, the clear start is refused with `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_req_i | input | 1 | Translation request |
| xl_addr_i | input | 23 | Logical address |
| xl_wr_i | input | 1 | Request is a write |
| xl_priv_i | input | 1 | Request runs privileged |
| xl_vld_o | output | 1 | Result valid (one cycle after request) |
| xl_paddr_o | output | 24 | Physical address, zero when blocked |
| xl_fault_o | output | 1 | Map entry was invalid |
| xl_pviol_o | output | 1 | Write-protection violation |
| map_we_i | input | 1 | Map entry load |
| map_priv_i | input | 1 | Privilege of the load |
| map_bank_i | input | 1 | Bank written |
| map_idx_i | input | 10 | Entry index |
| map_pbn_i | input | 11 | Physical block number |
| map_valid_i | input | 1 | Valid bit written |
| sel_req_i | input | 1 | Active-bank select request |
| sel_priv_i | input | 1 | Privilege of the select |
| sel_bank_i | input | 1 | Bank to make active |
| clr_req_i | input | 1 | Start clearing the inactive bank |
| clr_priv_i | input | 1 | Privilege of the clear start |
| prot_we_i | input | 1 | Protect word write |
| prot_priv_i | input | 1 | Privilege of the protect write |
| prot_idx_i | input | 8 | Protect word index |
| prot_data_i | input | 32 | Protect word contents |
| act_bank_o | output | 1 | Bank serving translations |
| clr_busy_o | output | 1 | Background clear running |
| cfg_err_o | output | 1 | A supervisory request was refused last cycle |

## Verification
Two functions can meet in one clock: a translation and an update of the very entry or protect word it reads, and a bank select together with a clear start. The bench provokes the first by driving a map load and a protect write aimed at the translated page and granule in the same cycle as an unprivileged write translation. It expects the old block number and old protect bit, then repeats the translation to see the new ones. The second is provoked by raising select and clear start together. The bench judges it by the new `act_bank_o`, a low `clr_busy_o` and a raised `cfg_err_o`. Random traffic also mixes loads to both banks with translations, so that reads of the active bank overlap writes elsewhere.

// File: rtl/mxl_pkg.sv
`timescale 1ns/1ps
package mxl_pkg;

  localparam int unsigned MXL_BANKS = 2;

  typedef struct packed {
    logic fault;
    logic pviol;
    logic pass;
  } mxl_verdict_t;

  function automatic mxl_verdict_t mxl_judge(input logic valid, input logic wr,
                                             input logic priv, input logic prot);
    mxl_verdict_t r;
    r.fault = !valid;
    r.pviol = valid && wr && !priv && prot;
    r.pass  = valid && !r.pviol;
    return r;
  endfunction

endpackage

// File: rtl/mxl_bank_ctrl.sv
`timescale 1ns/1ps
module mxl_bank_ctrl #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_req_i,
  input  logic             sel_priv_i,
  input  logic             sel_bank_i,
  input  logic             clr_req_i,
  input  logic             clr_priv_i,
  output logic             act_bank_o,
  output logic             clr_busy_o,
  output logic             clr_bank_o,
  output logic             clr_we_o,
  output logic [IDX_W-1:0] clr_idx_o,
  output logic             sel_refused_o,
  output logic             clr_refused_o
);

  logic             act_q, busy_q, cbank_q;
  logic [IDX_W-1:0] cnt_q;
  logic             sel_ok, clr_ok, sweep_last;

  assign sel_ok     = sel_req_i && sel_priv_i && !(busy_q && (sel_bank_i == cbank_q));
  assign clr_ok     = clr_req_i && clr_priv_i && !busy_q && !sel_req_i;
  assign sweep_last = busy_q && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      busy_q  <= 1'b0;
      cbank_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (sel_ok) act_q <= sel_bank_i;
      if (clr_ok) begin
        busy_q  <= 1'b1;
        cbank_q <= ~act_q;
        cnt_q   <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (sweep_last) busy_q <= 1'b0;
      end
    end
  end

  assign act_bank_o    = act_q;
  assign clr_busy_o    = busy_q;
  assign clr_bank_o    = cbank_q;
  assign clr_we_o      = busy_q;
  assign clr_idx_o     = cnt_q;
  assign sel_refused_o = sel_req_i && !sel_ok;
  assign clr_refused_o = clr_req_i && !clr_ok;

endmodule

// File: rtl/mxl_map_file.sv
`timescale 1ns/1ps
module mxl_map_file #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PBN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we_i,
  input  logic             ld_bank_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [PBN_W-1:0] ld_pbn_i,
  input  logic             ld_valid_i,
  input  logic             clr_we_i,
  input  logic             clr_bank_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic             rd_bank_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PBN_W-1:0] rd_pbn_o,
  output logic             rd_valid_o
);

  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [PBN_W-1:0] bank_pbn [mxl_pkg::MXL_BANKS];
  logic [mxl_pkg::MXL_BANKS-1:0] bank_vld;

  for (genvar b = 0; b < mxl_pkg::MXL_BANKS; b++) begin : g_bank
    logic [PBN_W-1:0]   pbn_mem [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic               ld_hit, cl_hit;

    assign ld_hit = ld_we_i  && (ld_bank_i  == 1'(b));
    assign cl_hit = clr_we_i && (clr_bank_i == 1'(b));

    always_ff @(posedge clk) begin
      if (ld_hit) pbn_mem[ld_idx_i] <= ld_pbn_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else begin
        if (ld_hit) vld_q[ld_idx_i]  <= ld_valid_i;
        if (cl_hit) vld_q[clr_idx_i] <= 1'b0;
      end
    end

    assign bank_pbn[b] = pbn_mem[rd_idx_i];
    assign bank_vld[b] = vld_q[rd_idx_i];
  end

  assign rd_pbn_o   = bank_pbn[rd_bank_i];
  assign rd_valid_o = bank_vld[rd_bank_i];

endmodule

// File: rtl/mxl_prot_map.sv
`timescale 1ns/1ps
module mxl_prot_map #(
  parameter int unsigned PWI_W       = 8,
  parameter int unsigned PROT_WORD_W = 32,
  localparam int unsigned PWB_W      = $clog2(PROT_WORD_W),
  localparam int unsigned WORDS      = 1 << PWI_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [PWI_W-1:0]       widx_i,
  input  logic [PROT_WORD_W-1:0] wdata_i,
  input  logic [PWI_W-1:0]       rd_word_i,
  input  logic [PWB_W-1:0]       rd_bit_i,
  output logic                   rd_prot_o
);

  logic [PROT_WORD_W-1:0] words_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) words_q[i] <= '0;
    end else if (we_i) begin
      words_q[widx_i] <= wdata_i;
    end
  end

  assign rd_prot_o = words_q[rd_word_i][rd_bit_i];

endmodule

// File: rtl/mxl_translate.sv
`timescale 1ns/1ps
module mxl_translate #(
  parameter int unsigned IDX_W       = 10,
  parameter int unsigned PBN_W       = 11,
  parameter int unsigned OFF_W       = 13,
  parameter int unsigned GRAN_W      = 11,
  parameter int unsigned PROT_WORD_W = 32,
  localparam int unsigned LA_W       = IDX_W + OFF_W,
  localparam int unsigned PA_W       = PBN_W + OFF_W,
  localparam int unsigned GRAN_BITS  = PA_W - GRAN_W,
  localparam int unsigned PWB_W      = $clog2(PROT_WORD_W),
  localparam int unsigned PWI_W      = GRAN_BITS - PWB_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xl_req_i,
  input  logic [LA_W-1:0]        xl_addr_i,
  input  logic                   xl_wr_i,
  input  logic                   xl_priv_i,
  output logic                   xl_vld_o,
  output logic [PA_W-1:0]        xl_paddr_o,
  output logic                   xl_fault_o,
  output logic                   xl_pviol_o,
  input  logic                   map_we_i,
  input  logic                   map_priv_i,
  input  logic                   map_bank_i,
  input  logic [IDX_W-1:0]       map_idx_i,
  input  logic [PBN_W-1:0]       map_pbn_i,
  input  logic                   map_valid_i,
  input  logic                   sel_req_i,
  input  logic                   sel_priv_i,
  input  logic                   sel_bank_i,
  input  logic                   clr_req_i,
  input  logic                   clr_priv_i,
  input  logic                   prot_we_i,
  input  logic                   prot_priv_i,
  input  logic [PWI_W-1:0]       prot_idx_i,
  input  logic [PROT_WORD_W-1:0] prot_data_i,
  output logic                   act_bank_o,
  output logic                   clr_busy_o,
  output logic                   cfg_err_o
);

  import mxl_pkg::*;

  function automatic logic [IDX_W-1:0] page_of(input logic [LA_W-1:0] la);
    return la[LA_W-1:OFF_W];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PBN_W-1:0] pbn,
                                              input logic [LA_W-1:0] la);
    return {pbn, la[OFF_W-1:0]};
  endfunction

  function automatic logic [PWI_W-1:0] prot_word_of(input logic [PA_W-1:0] pa);
    return pa[PA_W-1:GRAN_W+PWB_W];
  endfunction

  function automatic logic [PWB_W-1:0] prot_bit_of(input logic [PA_W-1:0] pa);
    return pa[GRAN_W+PWB_W-1:GRAN_W];
  endfunction

  // bank control
  logic             clr_bank, clr_we, sel_refused, clr_refused;
  logic [IDX_W-1:0] clr_idx;

  mxl_bank_ctrl #(.IDX_W(IDX_W)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_req_i    (sel_req_i),
    .sel_priv_i   (sel_priv_i),
    .sel_bank_i   (sel_bank_i),
    .clr_req_i    (clr_req_i),
    .clr_priv_i   (clr_priv_i),
    .act_bank_o   (act_bank_o),
    .clr_busy_o   (clr_busy_o),
    .clr_bank_o   (clr_bank),
    .clr_we_o     (clr_we),
    .clr_idx_o    (clr_idx),
    .sel_refused_o(sel_refused),
    .clr_refused_o(clr_refused)
  );

  // supervisory gating, named for the checker
  logic map_acc, map_refused, prot_acc, prot_refused, cfg_err_d;
  assign map_acc      = map_we_i && map_priv_i && !(clr_busy_o && (map_bank_i == clr_bank));
  assign map_refused  = map_we_i && !map_acc;
  assign prot_acc     = prot_we_i && prot_priv_i;
  assign prot_refused = prot_we_i && !prot_priv_i;
  assign cfg_err_d    = map_refused || prot_refused || sel_refused || clr_refused;

  // map storage
  logic [PBN_W-1:0] rd_pbn;
  logic             rd_valid;

  mxl_map_file #(.IDX_W(IDX_W), .PBN_W(PBN_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_we_i   (map_acc),
    .ld_bank_i (map_bank_i),
    .ld_idx_i  (map_idx_i),
    .ld_pbn_i  (map_pbn_i),
    .ld_valid_i(map_valid_i),
    .clr_we_i  (clr_we),
    .clr_bank_i(clr_bank),
    .clr_idx_i (clr_idx),
    .rd_bank_i (act_bank_o),
    .rd_idx_i  (page_of(xl_addr_i)),
    .rd_pbn_o  (rd_pbn),
    .rd_valid_o(rd_valid)
  );

  // protection bitmap
  logic [PA_W-1:0] pa_c;
  logic            prot_c;
  assign pa_c = join_pa(rd_pbn, xl_addr_i);

  mxl_prot_map #(.PWI_W(PWI_W), .PROT_WORD_W(PROT_WORD_W)) u_prot (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (prot_acc),
    .widx_i   (prot_idx_i),
    .wdata_i  (prot_data_i),
    .rd_word_i(prot_word_of(pa_c)),
    .rd_bit_i (prot_bit_of(pa_c)),
    .rd_prot_o(prot_c)
  );

  // verdict and result register
  mxl_verdict_t verdict_c;
  assign verdict_c = mxl_judge(rd_valid, xl_wr_i, xl_priv_i, prot_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_vld_o   <= 1'b0;
      xl_paddr_o <= '0;
      xl_fault_o <= 1'b0;
      xl_pviol_o <= 1'b0;
      cfg_err_o  <= 1'b0;
    end else begin
      xl_vld_o   <= xl_req_i;
      xl_paddr_o <= (xl_req_i && verdict_c.pass) ? pa_c : '0;
      xl_fault_o <= xl_req_i && verdict_c.fault;
      xl_pviol_o <= xl_req_i && verdict_c.pviol;
      cfg_err_o  <= cfg_err_d;
    end
  end

endmodule

// File: rtl/mxl_translate_chk.sv
`timescale 1ns/1ps
module mxl_translate_chk #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PA_W  = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xl_req_i,
  input logic            xl_wr_i,
  input logic            xl_vld_o,
  input logic [PA_W-1:0] xl_paddr_o,
  input logic            xl_fault_o,
  input logic            xl_pviol_o,
  input logic            map_we_i,
  input logic            map_priv_i,
  input logic            prot_we_i,
  input logic            prot_priv_i,
  input logic            sel_req_i,
  input logic            sel_priv_i,
  input logic            clr_busy_o,
  input logic            act_bank_o,
  input logic            cfg_err_o
);

  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [IDX_W:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_run <= '0;
    else if (clr_busy_o) busy_run <= busy_run + 1'b1;
    else                 busy_run <= '0;
  end

  // R1
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req_i |=> xl_vld_o);

  // R2
  fault_blocks_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault_o |-> (xl_paddr_o == '0) && !xl_pviol_o);

  // R3
  read_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req_i && !xl_wr_i) |=> !xl_pviol_o);

  // R4
  unpriv_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((map_we_i && !map_priv_i) || (prot_we_i && !prot_priv_i) || (sel_req_i && !sel_priv_i))
    |=> cfg_err_o);

  // R5
  sweep_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_busy_o) |-> (busy_run == (IDX_W+1)'(ENTRIES)));

  // R6
  bank_held_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy_o |=> $stable(act_bank_o));

endmodule

bind mxl_translate mxl_translate_chk #(.IDX_W(IDX_W), .PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xl_req_i   (xl_req_i),
  .xl_wr_i    (xl_wr_i),
  .xl_vld_o   (xl_vld_o),
  .xl_paddr_o (xl_paddr_o),
  .xl_fault_o (xl_fault_o),
  .xl_pviol_o (xl_pviol_o),
  .map_we_i   (map_we_i),
  .map_priv_i (map_priv_i),
  .prot_we_i  (prot_we_i),
  .prot_priv_i(prot_priv_i),
  .sel_req_i  (sel_req_i),
  .sel_priv_i (sel_priv_i),
  .clr_busy_o (clr_busy_o),
  .act_bank_o (act_bank_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/test_mxl_translate.sv
`timescale 1ns/1ps
module test_mxl_translate;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        xl_req, xl_wr, xl_priv, xl_vld, xl_fault, xl_pviol;
  logic [22:0] xl_addr;
  logic [23:0] xl_paddr;
  logic        map_we, map_priv, map_bank, map_valid;
  logic [9:0]  map_idx;
  logic [10:0] map_pbn;
  logic        sel_req, sel_priv, sel_bank, clr_req, clr_priv;
  logic        prot_we, prot_priv;
  logic [7:0]  prot_idx;
  logic [31:0] prot_data;
  logic        act_bank, clr_busy, cfg_err;

  mxl_translate i_mxl_translate (
    .clk(clk), .rst_n(rst_n),
    .xl_req_i(xl_req), .xl_addr_i(xl_addr), .xl_wr_i(xl_wr), .xl_priv_i(xl_priv),
    .xl_vld_o(xl_vld), .xl_paddr_o(xl_paddr), .xl_fault_o(xl_fault), .xl_pviol_o(xl_pviol),
    .map_we_i(map_we), .map_priv_i(map_priv), .map_bank_i(map_bank), .map_idx_i(map_idx),
    .map_pbn_i(map_pbn), .map_valid_i(map_valid),
    .sel_req_i(sel_req), .sel_priv_i(sel_priv), .sel_bank_i(sel_bank),
    .clr_req_i(clr_req), .clr_priv_i(clr_priv),
    .prot_we_i(prot_we), .prot_priv_i(prot_priv), .prot_idx_i(prot_idx), .prot_data_i(prot_data),
    .act_bank_o(act_bank), .clr_busy_o(clr_busy), .cfg_err_o(cfg_err)
  );

  int n_vec = 0, n_bad = 0, n_ticks = 0;

  // reference state
  bit [10:0] m_pbn [2][1024];
  bit        m_v   [2][1024];
  bit [31:0] m_prot[256];
  bit        m_act = 0, m_busy = 0, m_cbank = 0;

  task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expv);
    n_vec++;
    if (actual !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expv);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1; n_ticks++;
  endtask

  task automatic idle;
    xl_req = 0; xl_wr = 0; xl_priv = 0; xl_addr = '0;
    map_we = 0; map_priv = 0; map_bank = 0; map_idx = '0; map_pbn = '0; map_valid = 0;
    sel_req = 0; sel_priv = 0; sel_bank = 0; clr_req = 0; clr_priv = 0;
    prot_we = 0; prot_priv = 0; prot_idx = '0; prot_data = '0;
  endtask

  // expected translation from the reference, computed by bit arithmetic
  function automatic void ref_xl(input bit [22:0] la, input bit wr, input bit priv,
                                 output bit f, output bit pv, output bit [23:0] pa);
    int unsigned pg   = la / 8192;
    int unsigned off  = la % 8192;
    int unsigned phys = m_pbn[m_act][pg] * 8192 + off;
    int unsigned g    = phys / 2048;
    bit prot = m_prot[g / 32][g % 32];
    f  = !m_v[m_act][pg];
    pv = !f && wr && !priv && prot;
    pa = (f || pv) ? 24'd0 : 24'(phys);
  endfunction

  task automatic chk_xl(input string tag, input bit f, input bit pv, input bit [23:0] pa);
    chk({tag, " vld"},   32'(xl_vld),   32'd1);
    chk({tag, " fault"}, 32'(xl_fault), 32'(f));
    chk({tag, " pviol"}, 32'(xl_pviol), 32'(pv));
    chk({tag, " paddr"}, 32'(xl_paddr), 32'(pa));
  endtask

  task automatic do_xl(input string tag, input bit [22:0] la, input bit wr, input bit priv);
    bit f, pv; bit [23:0] pa;
    ref_xl(la, wr, priv, f, pv, pa);
    xl_req = 1; xl_addr = la; xl_wr = wr; xl_priv = priv;
    tick; idle;
    chk_xl(tag, f, pv, pa);
  endtask

  task automatic do_ld(input string tag, input bit bank, input bit [9:0] idx,
                       input bit [10:0] pbn, input bit v, input bit priv);
    bit refuse = !priv || (m_busy && bank == m_cbank);
    map_we = 1; map_priv = priv; map_bank = bank; map_idx = idx; map_pbn = pbn; map_valid = v;
    tick; idle;
    chk({tag, " cfg_err"}, 32'(cfg_err), 32'(refuse));
    if (!refuse) begin m_pbn[bank][idx] = pbn; m_v[bank][idx] = v; end
  endtask

  task automatic do_pw(input string tag, input bit [7:0] idx, input bit [31:0] d, input bit priv);
    prot_we = 1; prot_priv = priv; prot_idx = idx; prot_data = d;
    tick; idle;
    chk({tag, " cfg_err"}, 32'(cfg_err), 32'(!priv));
    if (priv) m_prot[idx] = d;
  endtask

  task automatic do_sel(input string tag, input bit bank, input bit priv);
    bit refuse = !priv || (m_busy && bank == m_cbank);
    sel_req = 1; sel_priv = priv; sel_bank = bank;
    tick; idle;
    if (!refuse) m_act = bank;
    chk({tag, " cfg_err"}, 32'(cfg_err), 32'(refuse));
    chk({tag, " act"},     32'(act_bank), 32'(m_act));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    bit f, pv; bit [23:0] pa;
    int start;
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    repeat (3) tick;
    rst_n = 1;
    tick;

    // R8 reset state
    chk("R8 act",   32'(act_bank), 32'd0);
    chk("R8 busy",  32'(clr_busy), 32'd0);
    chk("R8 err",   32'(cfg_err),  32'd0);
    chk("R8 vld",   32'(xl_vld),   32'd0);
    do_xl("R8 empty map", 23'h12345, 1'b0, 1'b1);
    sel_req = 1; sel_priv = 1; sel_bank = 1; tick; idle; m_act = 1;
    do_xl("R8 empty bank1", 23'h7ABCD, 1'b1, 1'b0);
    do_sel("R8 back", 1'b0, 1'b1);

    // R1 basic, R2 invalid
    do_ld("R1 load", 1'b0, 10'd3, 11'h5A5, 1'b1, 1'b1);
    do_xl("R1 hit", {10'd3, 13'h1F0F}, 1'b0, 1'b0);
    do_ld("R2 drop", 1'b0, 10'd3, 11'h5A5, 1'b0, 1'b1);
    do_xl("R2 invalid", {10'd3, 13'h0004}, 1'b1, 1'b0);

    // R3 protection: pbn 0x40 -> granules 0x100..0x103, word 8 bits 0..3
    do_ld("R3 load", 1'b0, 10'd9, 11'h040, 1'b1, 1'b1);
    do_pw("R3 prot", 8'd8, 32'h0000_0002, 1'b1);
    do_xl("R3 unpriv wr prot",   {10'd9, 13'h0800}, 1'b1, 1'b0);
    do_xl("R3 unpriv wr open",   {10'd9, 13'h1000}, 1'b1, 1'b0);
    do_xl("R3 unpriv rd prot",   {10'd9, 13'h0FFF}, 1'b0, 1'b0);
    do_xl("R3 priv wr prot",     {10'd9, 13'h0801}, 1'b1, 1'b1);

    // R4 unprivileged supervisory requests
    do_ld("R4 ld", 1'b0, 10'd9, 11'h3FF, 1'b1, 1'b0);
    do_xl("R4 ld ignored", {10'd9, 13'h0123}, 1'b0, 1'b0);
    do_pw("R4 pw", 8'd8, 32'h0, 1'b0);
    do_xl("R4 pw ignored", {10'd9, 13'h0900}, 1'b1, 1'b0);
    do_sel("R4 sel", 1'b1, 1'b0);
    clr_req = 1; clr_priv = 0; tick; idle;
    chk("R4 clr err",  32'(cfg_err),  32'd1);
    chk("R4 clr busy", 32'(clr_busy), 32'd0);

    // constrained random traffic (R1 R2 R3 R4 R7 mix)
    for (int it = 0; it < 2500; it++) begin
      int unsigned op = $urandom_range(0, 9);
      bit [9:0] idx = ($urandom_range(0, 3) == 0) ? 10'($urandom) : 10'($urandom_range(0, 15));
      if (op <= 2)
        do_ld("R1 rnd ld", 1'($urandom), idx, 11'($urandom), ($urandom_range(0, 5) != 0),
              ($urandom_range(0, 9) != 0));
      else if (op == 3)
        do_pw("R3 rnd pw", 8'($urandom), $urandom, ($urandom_range(0, 4) != 0));
      else if (op == 9)
        do_sel("R4 rnd sel", 1'($urandom), ($urandom_range(0, 4) != 0));
      else
        do_xl("R1 rnd xl", {idx, 13'($urandom)}, 1'($urandom), 1'($urandom));
    end

    // R5/R6 background clear
    do_ld("R5 prep", ~m_act, 10'd5, 11'h111, 1'b1, 1'b1);
    do_ld("R5 prep act", m_act, 10'd6, 11'h222, 1'b1, 1'b1);
    clr_req = 1; clr_priv = 1; tick; idle;
    start = n_ticks;
    m_busy = 1; m_cbank = ~m_act;
    chk("R5 busy", 32'(clr_busy), 32'd1);
    chk("R5 err",  32'(cfg_err),  32'd0);
    do_sel("R6 sel clearing", m_cbank, 1'b1);
    do_ld("R6 ld clearing", m_cbank, 10'd7, 11'h333, 1'b1, 1'b1);
    clr_req = 1; clr_priv = 1; tick; idle;
    chk("R6 second clr", 32'(cfg_err), 32'd1);
    do_xl("R5 active during sweep", {10'd6, 13'h0ABC}, 1'b0, 1'b0);
    while (clr_busy && (n_ticks - start) < 3000) tick;
    chk("R5 busy length", 32'(n_ticks - start), 32'd1024);
    for (int i = 0; i < 1024; i++) m_v[m_cbank][i] = 0;
    m_busy = 0;
    do_sel("R5 sel cleared", m_cbank, 1'b1);
    do_xl("R5 cleared entry", {10'd5, 13'h0010}, 1'b0, 1'b1);

    // R9 select and clear start together
    sel_req = 1; sel_priv = 1; sel_bank = ~m_act; clr_req = 1; clr_priv = 1;
    tick; idle;
    m_act = ~m_act;
    chk("R9 act",  32'(act_bank), 32'(m_act));
    chk("R9 err",  32'(cfg_err),  32'd1);
    chk("R9 busy", 32'(clr_busy), 32'd0);

    // R7 same-cycle update and translation
    do_ld("R7 prep", m_act, 10'd12, 11'h0A0, 1'b1, 1'b1);
    do_pw("R7 prep prot", 8'h14, 32'h0, 1'b1);
    ref_xl({10'd12, 13'h0800}, 1'b1, 1'b0, f, pv, pa);
    xl_req = 1; xl_addr = {10'd12, 13'h0800}; xl_wr = 1; xl_priv = 0;
    map_we = 1; map_priv = 1; map_bank = m_act; map_idx = 10'd12; map_pbn = 11'h0A1; map_valid = 1;
    prot_we = 1; prot_priv = 1; prot_idx = 8'h14; prot_data = 32'h0000_0020;
    tick; idle;
    chk_xl("R7 old contents", f, pv, pa);
    m_pbn[m_act][12] = 11'h0A1; m_prot[8'h14] = 32'h0000_0020;
    do_xl("R7 new contents", {10'd12, 13'h0800}, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule